// File: doc/BRIEF.md
# DDR SDRAM power-up initialization sequencer

This block takes a DDR SDRAM from power-on to a usable state. It waits for the system to report that supplies and the clock are stable. It then keeps clock-enable low and issues only no-operation commands for a long settling period. After that it raises clock-enable and issues the required series of commands: precharge-all, the extended mode load, a mode load that resets the DLL, a second precharge-all, two auto-refreshes and a final mode load that clears the DLL reset. It spaces each command by its own cycle-count timing parameter. It raises a ready flag only once the DLL has had its lock time.

The mode and extended-mode codes arrive on input buses and are placed on the address pins during the load commands. A build-time switch can move the two auto-refreshes so that they come directly after the DLL-reset load and before the second precharge-all. The data bus enable is held off for the whole sequence. All waits are parameters in clock cycles, so the same block can be used at any clock rate.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until `pwr_ok` is seen high, `cke` is 0, the command pins {cs_n,ras_n,cas_n,we_n} carry NOP = 4'b0111, and `init_done` is 0.
- R2: After `pwr_ok` is sampled high, `cke` stays 0 with only NOP commands for at least T_PWRUP cycles. It then rises in a cycle whose command is NOP and never falls again until reset.
- R3: With REF_EARLY=0, the non-NOP commands come in this order: precharge-all, extended load, DLL-reset mode load, precharge-all, auto-refresh, auto-refresh, final mode load.
- R4: With REF_EARLY=1, the order is: precharge-all, extended load, DLL-reset mode load, auto-refresh, auto-refresh, precharge-all, final mode load.
- R5: A precharge-all is command 4'b0010 with address bit 10 high. Auto-refresh is 4'b0001, and a mode or extended load is 4'b0000.
- R6: The extended load drives bank address 2'b01 (bit 0 high, bit 1 low) and puts `emr_code` unchanged on the address pins.
- R7: Both mode loads drive bank address 2'b00. The DLL-reset load drives `mr_code` with address bit 8 forced to 1. The final load drives `mr_code` with bit 8 forced to 0. All other bits are unchanged.
- R8: After a precharge-all, at least T_RP cycles pass before the next non-NOP command. After any load the gap is at least T_MRD cycles, and after an auto-refresh it is at least T_RFC cycles. Every cycle between commands is NOP.
- R9: `init_done` rises no earlier than T_DLL cycles after the DLL-reset load and no earlier than T_MRD cycles after the final load. It rises within 2 cycles of the later of those two points. Once high it stays high, with `cke` high and NOP on the command pins.
- R10: `dq_oe` is 0 in every cycle, so the data and strobe lines remain high-impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supplies and clock are stable |
| mr_code | input | AW | Mode register operating code |
| emr_code | input | AW | Extended mode register code |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | AW | Address pins |
| ba | output | BAW | Bank address |
| dq_oe | output | 1 | Data bus output enable (always 0) |
| init_done | output | 1 | Sequence complete, memory ready |

## Verification
The gap assertions measure the distance from the previous non-NOP command. They assume the codes on `mr_code` and `emr_code` are held steady while a load is issued. The bench sets these codes before it releases reset and does not change them during a run. It raises `pwr_ok` once per run and never lowers it mid-sequence, because the assertions on `cke` expect it to rise only once after each reset. A reset in the middle of the sequence is applied through `rst_n`, which disables the clocked properties. It is checked only at the ports.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int AW        = 13,
  parameter int BAW       = 2,
  parameter int T_PWRUP   = 40000,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 15,
  parameter int T_DLL     = 200,
  parameter bit REF_EARLY = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwr_ok,
  input  logic [AW-1:0]  mr_code,
  input  logic [AW-1:0]  emr_code,
  output logic           cke,
  output logic           cs_n,
  output logic           ras_n,
  output logic           cas_n,
  output logic           we_n,
  output logic [AW-1:0]  addr,
  output logic [BAW-1:0] ba,
  output logic           dq_oe,
  output logic           init_done
);
  localparam int M1   = (T_PWRUP > T_RFC) ? T_PWRUP : T_RFC;
  localparam int M2   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAXW = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXW + 1);
  localparam int DW   = $clog2(T_DLL + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  localparam logic [AW-1:0] ONE  = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] BIT10 = ONE << 10;
  localparam logic [AW-1:0] BIT8  = ONE << 8;

  typedef enum logic [3:0] {
    S_OFF, S_PWR, S_CKE, S_PRE1, S_EMR, S_MRD, S_PRE2,
    S_AR1, S_AR2, S_MRO, S_DLL, S_DONE
  } st_t;

  st_t           st, nxt;
  logic [CW-1:0] cnt, dwell;
  logic [DW-1:0] dll_cnt;
  logic [3:0]    cmd4;
  logic          first;

  assign first = (cnt == '0);

  always_comb begin
    dwell = CW'(1);
    nxt   = st;
    case (st)
      S_PWR:  begin dwell = CW'(T_PWRUP); nxt = S_CKE;  end
      S_CKE:  begin dwell = CW'(1);       nxt = S_PRE1; end
      S_PRE1: begin dwell = CW'(T_RP);    nxt = S_EMR;  end
      S_EMR:  begin dwell = CW'(T_MRD);   nxt = S_MRD;  end
      S_MRD:  begin dwell = CW'(T_MRD);   nxt = REF_EARLY ? S_AR1 : S_PRE2; end
      S_PRE2: begin dwell = CW'(T_RP);    nxt = REF_EARLY ? S_MRO : S_AR1;  end
      S_AR1:  begin dwell = CW'(T_RFC);   nxt = S_AR2;  end
      S_AR2:  begin dwell = CW'(T_RFC);   nxt = REF_EARLY ? S_PRE2 : S_MRO; end
      S_MRO:  begin dwell = CW'(T_MRD);   nxt = S_DLL;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      cnt     <= '0;
      dll_cnt <= '0;
    end else begin
      if (st == S_MRD && first)
        dll_cnt <= DW'(1);
      else if (dll_cnt != '0 && dll_cnt != DW'(T_DLL))
        dll_cnt <= dll_cnt + 1'b1;
      case (st)
        S_OFF:  if (pwr_ok) st <= S_PWR;
        S_DLL:  if (dll_cnt == DW'(T_DLL)) st <= S_DONE;
        S_DONE: ;
        default:
          if (cnt == dwell - CW'(1)) begin
            cnt <= '0;
            st  <= nxt;
          end else begin
            cnt <= cnt + 1'b1;
          end
      endcase
    end
  end

  always_comb begin
    cmd4 = C_NOP;
    addr = '0;
    ba   = '0;
    if (first) begin
      case (st)
        S_PRE1, S_PRE2: begin cmd4 = C_PRE; addr = BIT10; end
        S_AR1, S_AR2:   cmd4 = C_REF;
        S_EMR: begin cmd4 = C_LMR; addr = emr_code; ba = BAW'(1); end
        S_MRD: begin cmd4 = C_LMR; addr = mr_code | BIT8; end
        S_MRO: begin cmd4 = C_LMR; addr = mr_code & ~BIT8; end
        default: ;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd4;
  assign cke       = (st != S_OFF) && (st != S_PWR);
  assign dq_oe     = 1'b0;
  assign init_done = (st == S_DONE);

  logic [3:0]    last_cmd;
  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cmd <= C_NOP;
      since    <= '0;
    end else if (cmd4 != C_NOP) begin
      last_cmd <= cmd4;
      since    <= CW'(1);
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  // R8
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd4 != C_NOP && last_cmd == C_PRE) |-> since >= CW'(T_RP));
  // R8
  mrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd4 != C_NOP && last_cmd == C_LMR) |-> since >= CW'(T_MRD));
  // R8
  rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd4 != C_NOP && last_cmd == C_REF) |-> since >= CW'(T_RFC));
  // R2
  low_cke_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd4 == C_NOP);
  // R2
  cke_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  // R9
  done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cke && cmd4 == C_NOP));
endmodule

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;
  localparam int AW = 13, BAW = 2;
  localparam int P_PWR = 50, P_RP = 3, P_MRD = 2, P_RFC = 8;
  localparam int P_DLL0 = 40, P_DLL1 = 10;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  logic clk = 0, rst_n = 0, pwr_ok = 0;
  logic [AW-1:0] mr_code = '0, emr_code = '0;
  always #10 clk = ~clk;

  logic cke0, cs0, ras0, cas0, we0, oe0, dn0;
  logic cke1, cs1, ras1, cas1, we1, oe1, dn1;
  logic [AW-1:0] a0, a1;
  logic [BAW-1:0] b0, b1;

  ddr_init_seq #(.AW(AW), .BAW(BAW), .T_PWRUP(P_PWR), .T_RP(P_RP), .T_MRD(P_MRD),
    .T_RFC(P_RFC), .T_DLL(P_DLL0), .REF_EARLY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .mr_code(mr_code), .emr_code(emr_code),
    .cke(cke0), .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0), .addr(a0), .ba(b0),
    .dq_oe(oe0), .init_done(dn0));

  ddr_init_seq #(.AW(AW), .BAW(BAW), .T_PWRUP(P_PWR), .T_RP(P_RP), .T_MRD(P_MRD),
    .T_RFC(P_RFC), .T_DLL(P_DLL1), .REF_EARLY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .mr_code(mr_code), .emr_code(emr_code),
    .cke(cke1), .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1), .addr(a1), .ba(b1),
    .dq_oe(oe1), .init_done(dn1));

  logic sel = 0;
  logic m_cke, m_oe, m_done;
  logic [3:0] m_cmd;
  logic [AW-1:0] m_addr;
  logic [BAW-1:0] m_ba;
  always_comb begin
    m_cke  = sel ? cke1 : cke0;
    m_cmd  = sel ? {cs1, ras1, cas1, we1} : {cs0, ras0, cas0, we0};
    m_addr = sel ? a1 : a0;
    m_ba   = sel ? b1 : b0;
    m_oe   = sel ? oe1 : oe0;
    m_done = sel ? dn1 : dn0;
  end

  int checks = 0, errors = 0;
  bit mon_en = 0;
  int cyc, n_cmd, cke_rise, done_rise, pwr_cyc;
  int bad_low, bad_fall, bad_oe, bad_post;
  logic [3:0] rise_cmd;
  int lc_cyc[16];
  logic [3:0] lc_cmd[16];
  logic [AW-1:0] lc_addr[16];
  logic [BAW-1:0] lc_ba[16];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) if (mon_en) begin
    cyc++;
    if (pwr_ok && pwr_cyc < 0) pwr_cyc = cyc;
    if (!m_cke && m_cmd != NOP) bad_low++;
    if (cke_rise >= 0 && !m_cke) bad_fall++;
    if (m_cke && cke_rise < 0) begin cke_rise = cyc; rise_cmd = m_cmd; end
    if (m_oe) bad_oe++;
    if (m_cmd != NOP && n_cmd < 16) begin
      lc_cyc[n_cmd] = cyc; lc_cmd[n_cmd] = m_cmd;
      lc_addr[n_cmd] = m_addr; lc_ba[n_cmd] = m_ba; n_cmd++;
    end
    if (done_rise >= 0 && (!m_done || m_cmd != NOP || !m_cke)) bad_post++;
    if (m_done && done_rise < 0) done_rise = cyc;
  end

  function automatic int need(input logic [3:0] c);
    if (c == PRE) return P_RP;
    if (c == REF) return P_RFC;
    return P_MRD;
  endfunction

  task automatic run_seq(input bit s, input bit early, input int dll,
                         input logic [AW-1:0] mr, input logic [AW-1:0] emr);
    logic [3:0] exp_ord[7];
    string rq;
    int lo;
    if (early) exp_ord = '{PRE, LMR, LMR, REF, REF, PRE, LMR};
    else       exp_ord = '{PRE, LMR, LMR, PRE, REF, REF, LMR};
    rq = early ? "R4" : "R3";
    @(posedge clk); #2;
    rst_n = 0; pwr_ok = 0; sel = s; mr_code = mr; emr_code = emr;
    mon_en = 0; cyc = 0; n_cmd = 0; cke_rise = -1; done_rise = -1; pwr_cyc = -1;
    bad_low = 0; bad_fall = 0; bad_oe = 0; bad_post = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!m_cke && m_cmd == NOP && !m_done, "R1", "reset outputs", {m_cke, m_cmd, m_done}, {1'b0, NOP, 1'b0});
    @(posedge clk); #2;
    rst_n = 1; mon_en = 1;
    repeat (20) @(posedge clk);
    @(negedge clk); #1;
    // R1 waiting for pwr_ok
    chk(!m_cke && m_cmd == NOP && !m_done, "R1", "idle before pwr_ok", {m_cke, m_cmd, m_done}, {1'b0, NOP, 1'b0});
    @(posedge clk); #2;
    pwr_ok = 1;
    for (int i = 0; i < 3000 && done_rise < 0; i++) @(posedge clk);
    repeat (10) @(posedge clk);
    @(negedge clk); #1;
    mon_en = 0;
    // R2
    chk(cke_rise - pwr_cyc - 1 >= P_PWR && cke_rise - pwr_cyc - 1 <= P_PWR + 2, "R2", "cke low cycles", cke_rise - pwr_cyc - 1, P_PWR);
    chk(rise_cmd == NOP, "R2", "command at cke rise", rise_cmd, NOP);
    chk(bad_low == 0, "R2", "commands while cke low", bad_low, 0);
    chk(bad_fall == 0, "R2", "cke falls", bad_fall, 0);
    // R3 / R4
    chk(n_cmd == 7, rq, "command count", n_cmd, 7);
    for (int i = 0; i < 7; i++)
      chk(lc_cmd[i] == exp_ord[i], rq, $sformatf("command %0d", i), lc_cmd[i], exp_ord[i]);
    // R5
    for (int i = 0; i < 7; i++)
      if (lc_cmd[i] == PRE) chk(lc_addr[i][10] == 1'b1, "R5", "precharge A10", lc_addr[i][10], 1);
    // R6
    chk(lc_ba[1] == 2'b01 && lc_addr[1] == emr, "R6", "extended load addr", lc_addr[1], emr);
    chk(lc_ba[1] == 2'b01, "R6", "extended load bank", lc_ba[1], 1);
    // R7
    chk(lc_addr[2] == (mr | 13'h100) && lc_ba[2] == 0, "R7", "DLL reset load", lc_addr[2], mr | 13'h100);
    chk(lc_addr[6] == (mr & ~13'h100) && lc_ba[6] == 0, "R7", "final load", lc_addr[6], mr & ~13'h100);
    // R8
    chk(lc_cyc[0] > cke_rise, "R8", "first command after cke", lc_cyc[0], cke_rise + 1);
    for (int i = 0; i < 6; i++)
      chk(lc_cyc[i+1] - lc_cyc[i] >= need(lc_cmd[i]), "R8", $sformatf("gap after %0d", i),
          lc_cyc[i+1] - lc_cyc[i], need(lc_cmd[i]));
    // R9
    lo = lc_cyc[2] + dll;
    if (lc_cyc[6] + P_MRD > lo) lo = lc_cyc[6] + P_MRD;
    chk(done_rise >= lo && done_rise <= lo + 2, "R9", "done rise cycle", done_rise, lo);
    chk(bad_post == 0, "R9", "after done", bad_post, 0);
    // R10
    chk(bad_oe == 0, "R10", "dq_oe cycles", bad_oe, 0);
  endtask

  task automatic mid_reset();
    @(posedge clk); #2;
    rst_n = 0; pwr_ok = 0; sel = 0;
    repeat (2) @(posedge clk); #2;
    rst_n = 1;
    @(posedge clk); #2;
    pwr_ok = 1;
    repeat (P_PWR + 20) @(posedge clk);
    @(negedge clk);
    chk(m_cke == 1'b1, "R2", "cke high mid sequence", m_cke, 1);
    #2 rst_n = 0;
    #3;
    // R1 reset mid sequence
    chk(!m_cke && m_cmd == NOP && !m_done, "R1", "mid-sequence reset", {m_cke, m_cmd, m_done}, {1'b0, NOP, 1'b0});
    @(posedge clk); #2;
    pwr_ok = 0;
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    run_seq(1'b0, 1'b0, P_DLL0, 13'h0032, 13'h0002);
    run_seq(1'b1, 1'b1, P_DLL1, 13'h0162, 13'h0040);
    run_seq(1'b0, 1'b0, P_DLL0, 13'h1FFF, 13'h1ABC);
    mid_reset();
    finish_run();
  end
endmodule